// File: doc/BRIEF.md
# Infrared-Capable Asynchronous Serial Port

This block is a byte-wide asynchronous serial transmitter and receiver. A host pushes bytes into an 8-entry transmit queue and pops received bytes from an 8-entry receive queue. Each frame is one start bit, eight data bits sent least significant bit first, and one stop bit. A power-of-two prescaler sets the rate of a sample tick, and one bit lasts 16 ticks.

With the infrared option set, the serial line carries pulses instead of levels. On transmit, each 0 bit becomes a short high pulse and each 1 bit sends nothing. On receive, each high pulse is read as a 0 bit. An internal loop can route the infrared transmit pulses straight into the receiver. The receive-ready output can be set by software or driven from the receive queue level. A clear-to-send input holds back the start of new frames.

Top module: `irUart`

## Requirements
- R1: After reset, txd is 1, rxEmpty is 1, txHalfEmpty is 1, and overrun, frameErr and irq are 0.
- R2: In level mode (irMode=0), a frame on txd is one low start bit, then 8 data bits LSB first, then one high stop bit. The line is high when idle. One tick is 2^presc clock cycles, and every bit lasts 16 ticks.
- R3: In infrared mode (irMode=1), txd rests low. Each 0 bit of the frame (start bit included) produces one high pulse of 3 ticks at the start of its bit time. A 1 bit produces no pulse.
- R4: In 16x mode (rx1x=0), a low level on rxd is taken as a start bit only if it is still low half a bit later. Each data bit is sampled at the middle of its bit time. The received byte is shown on rdData while rxEmpty is 0, and a cycle with rdEn=1 removes it. rdEn on an empty queue has no effect.
- R5: In infrared mode, a high pulse on rxd is received as a 0 bit and a bit time with no pulse as a 1 bit. With irLoop=1, the receiver takes the internal infrared transmit pulses in place of rxd.
- R6: In 1x mode (rx1x=1), the receiver samples the line once per bit, on the internal bit-clock edge. It takes the first low sample as the start bit and the next eight samples as data.
- R7: Each queue holds 8 bytes. txFull is 1 with 8 bytes queued, and a write while txFull is 1 is dropped. rxFull is 1 with 8 bytes held.
- R8: txHalfEmpty is 1 exactly when the transmit queue holds fewer than 4 bytes.
- R9: overrun is rewritten at every received character. It becomes 1 when the character arrives while the receive queue is full and no read is made in that cycle, and that character is discarded. It becomes 0 in every other case. A read in the same cycle as the arrival frees a slot, and the character is then stored.
- R10: frameErr is rewritten at every received character: 1 if the stop bit was sampled low, else 0. The character is stored in either case.
- R11: With rtsAuto=1, rts is 0 while the receive queue holds 7 or 8 bytes and 1 otherwise. With rtsAuto=0, rts follows rtsSoft.
- R12: A new frame starts only at a bit-clock edge while cts is 1. With cts at 0, queued bytes wait and txd stays idle.
- R13: irq is 1 while the receive queue is not empty, or overrun is 1, or frameErr is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| presc | input | 3 | Tick divider code; tick every 2^presc cycles |
| irMode | input | 1 | 1 selects infrared pulse coding |
| rx1x | input | 1 | 1 selects once-per-bit receive sampling |
| irLoop | input | 1 | 1 routes infrared transmit pulses into the receiver |
| rtsAuto | input | 1 | 1 drives rts from the receive queue level |
| rtsSoft | input | 1 | rts value when rtsAuto is 0 |
| wrEn | input | 1 | Push wrData into the transmit queue |
| wrData | input | 8 | Byte to transmit |
| txFull | output | 1 | Transmit queue holds 8 bytes |
| txHalfEmpty | output | 1 | Transmit queue holds fewer than 4 bytes |
| rdEn | input | 1 | Pop the receive queue head |
| rdData | output | 8 | Receive queue head |
| rxEmpty | output | 1 | Receive queue empty |
| rxFull | output | 1 | Receive queue holds 8 bytes |
| overrun | output | 1 | Last character arrived to a full queue |
| frameErr | output | 1 | Last character had a low stop bit |
| irq | output | 1 | Service request |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| cts | input | 1 | 1 permits new transmit frames |
| rts | output | 1 | 1 signals readiness to receive |

## Verification
The two functions that can land in the same cycle are a character arriving into the receive queue and a host read popping that queue, while the queue is full. The bench first measures the fixed delay from a start-bit edge to the arrival of the first byte. It then fills the queue and sends one character with no read, which must set overrun and discard that character. Next it sends another character and raises rdEn for exactly the arrival cycle. That case must clear overrun, keep the queue full, and leave the drained bytes in order with the new character last.

// File: rtl/irUartPkg.sv
package irUartPkg;
  typedef struct packed {
    logic txPop;
    logic rxPush;
    logic rxBad;
  } uartStrb_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxState_t;
endpackage

// File: rtl/irUartFifo.sv
module irUartFifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [CW-1:0] count,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          doPush, doPop;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign doPop  = pop && !empty;
  assign doPush = push && (!full || doPop);
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/irUartCtrl.sv
module irUartCtrl import irUartPkg::*; #(
  parameter int DATA_W  = 8,
  parameter int PRESC_W = 3,
  parameter int OVS     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PRESC_W-1:0] presc,
  input  logic              irMode,
  input  logic              rx1x,
  input  logic              irLoop,
  input  logic              cts,
  input  logic              rxd,
  input  logic [DATA_W-1:0] txHead,
  input  logic              txAvail,
  output uartStrb_t         strb,
  output logic [DATA_W-1:0] rxByte,
  output logic              txd
);
  localparam int DIVW    = (1 << PRESC_W) - 1;
  localparam int PHW     = $clog2(OVS);
  localparam int PULSE   = (3 * OVS) / 16;
  localparam int STRETCH = OVS - PULSE;
  localparam int FRAME   = DATA_W + 2;
  localparam int CNTW    = $clog2(FRAME);
  localparam int BW      = $clog2(DATA_W);

  // power-of-two prescaler and shared bit phase
  logic [DIVW-1:0] preCnt, limit;
  logic            tick, bitEdge;
  logic [PHW-1:0]  bitPh;

  assign limit   = DIVW'((1 << presc) - 1);
  assign tick    = (preCnt >= limit);
  assign bitEdge = tick && (bitPh == PHW'(OVS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      bitPh  <= '0;
    end else begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
      if (tick) bitPh <= bitPh + 1'b1;
    end
  end

  // transmitter
  logic              txBusy, txLast, txStart, txBit, irTx;
  logic [FRAME-1:0]  txSh;
  logic [CNTW-1:0]   txCnt;

  assign txLast  = (txCnt == CNTW'(FRAME - 1));
  assign txStart = bitEdge && (!txBusy || txLast) && txAvail && cts;
  assign txBit   = !txBusy || txSh[0];
  assign irTx    = irMode && !txBit && (bitPh < PHW'(PULSE));
  assign txd     = irMode ? irTx : txBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy <= 1'b0;
      txSh   <= '1;
      txCnt  <= '0;
    end else if (bitEdge) begin
      if (txBusy && !txLast) begin
        txSh  <= {1'b1, txSh[FRAME-1:1]};
        txCnt <= txCnt + 1'b1;
      end else if (txAvail && cts) begin
        txSh   <= {1'b1, txHead, 1'b0};
        txCnt  <= '0;
        txBusy <= 1'b1;
      end else begin
        txBusy <= 1'b0;
      end
    end
  end

  // receive line: synchroniser, loop select, pulse stretcher
  logic [1:0]     rxSync;
  logic           rawIn, lineIr, rxLine;
  logic [PHW-1:0] strCnt;

  assign rawIn  = (irMode && irLoop) ? irTx : rxSync[1];
  assign lineIr = !(rawIn || (strCnt != '0));
  assign rxLine = irMode ? lineIr : rawIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSync <= 2'b11;
      strCnt <= '0;
    end else begin
      rxSync <= {rxSync[0], rxd};
      if (!irMode)              strCnt <= '0;
      else if (tick && rawIn)   strCnt <= PHW'(STRETCH);
      else if (tick && strCnt != '0) strCnt <= strCnt - 1'b1;
    end
  end

  // receiver
  rxState_t          rxSt;
  logic [PHW-1:0]    rxPh;
  logic [BW-1:0]     rxBitN;
  logic [DATA_W-1:0] rxSh;
  logic              step, midHit, fullHit;

  assign step    = rx1x ? bitEdge : tick;
  assign midHit  = rx1x || (rxPh == PHW'(OVS / 2 - 1));
  assign fullHit = rx1x || (rxPh == PHW'(OVS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSt   <= RX_IDLE;
      rxPh   <= '0;
      rxBitN <= '0;
      rxSh   <= '0;
    end else if (step) begin
      case (rxSt)
        RX_IDLE: if (!rxLine) begin
          rxSt   <= rx1x ? RX_DATA : RX_START;
          rxPh   <= '0;
          rxBitN <= '0;
        end
        RX_START: if (midHit) begin
          rxSt <= rxLine ? RX_IDLE : RX_DATA;
          rxPh <= '0;
        end else rxPh <= rxPh + 1'b1;
        RX_DATA: if (fullHit) begin
          rxSh   <= {rxLine, rxSh[DATA_W-1:1]};
          rxPh   <= '0;
          rxBitN <= rxBitN + 1'b1;
          if (rxBitN == BW'(DATA_W - 1)) rxSt <= RX_STOP;
        end else rxPh <= rxPh + 1'b1;
        RX_STOP: if (fullHit) begin
          rxSt <= RX_IDLE;
          rxPh <= '0;
        end else rxPh <= rxPh + 1'b1;
        default: rxSt <= RX_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.txPop  = txStart;
    strb.rxPush = step && (rxSt == RX_STOP) && fullHit;
    strb.rxBad  = !rxLine;
  end
  assign rxByte = rxSh;
endmodule

// File: rtl/irUartData.sv
module irUartData import irUartPkg::*; #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  uartStrb_t         strb,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              rtsAuto,
  input  logic              rtsSoft,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] txHead,
  output logic              txAvail,
  output logic              txFull,
  output logic              txHalfEmpty,
  output logic              rxEmpty,
  output logic              rxFull,
  output logic              rts,
  output logic              overrun,
  output logic              frameErr,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [CW-1:0] txCount, rxCount;
  logic          txEmpty;

  irUartFifo #(.W(DATA_W), .DEPTH(DEPTH), .CW(CW)) txQ (
    .clk(clk), .rstN(rstN), .push(wrEn), .pop(strb.txPop), .din(wrData),
    .dout(txHead), .count(txCount), .full(txFull), .empty(txEmpty));

  irUartFifo #(.W(DATA_W), .DEPTH(DEPTH), .CW(CW)) rxQ (
    .clk(clk), .rstN(rstN), .push(strb.rxPush), .pop(rdEn), .din(rxByte),
    .dout(rdData), .count(rxCount), .full(rxFull), .empty(rxEmpty));

  assign txAvail     = !txEmpty;
  assign txHalfEmpty = (txCount < CW'(DEPTH / 2));
  assign rts         = rtsAuto ? (rxCount < CW'(DEPTH - 1)) : rtsSoft;
  assign irq         = !rxEmpty || overrun || frameErr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overrun  <= 1'b0;
      frameErr <= 1'b0;
    end else if (strb.rxPush) begin
      overrun  <= rxFull && !rdEn;
      frameErr <= strb.rxBad;
    end
  end
endmodule

// File: rtl/irUart.sv
module irUart import irUartPkg::*; #(
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 8,
  parameter int PRESC_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PRESC_W-1:0] presc,
  input  logic              irMode,
  input  logic              rx1x,
  input  logic              irLoop,
  input  logic              rtsAuto,
  input  logic              rtsSoft,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              txFull,
  output logic              txHalfEmpty,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rxEmpty,
  output logic              rxFull,
  output logic              overrun,
  output logic              frameErr,
  output logic              irq,
  input  logic              rxd,
  output logic              txd,
  input  logic              cts,
  output logic              rts
);
  uartStrb_t         strb;
  logic [DATA_W-1:0] txHead, rxByte;
  logic              txAvail;

  irUartCtrl #(.DATA_W(DATA_W), .PRESC_W(PRESC_W)) ctrl (
    .clk(clk), .rstN(rstN), .presc(presc), .irMode(irMode), .rx1x(rx1x),
    .irLoop(irLoop), .cts(cts), .rxd(rxd), .txHead(txHead), .txAvail(txAvail),
    .strb(strb), .rxByte(rxByte), .txd(txd));

  irUartData #(.DATA_W(DATA_W), .DEPTH(DEPTH)) data (
    .clk(clk), .rstN(rstN), .strb(strb), .rxByte(rxByte), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rtsAuto(rtsAuto), .rtsSoft(rtsSoft),
    .rdData(rdData), .txHead(txHead), .txAvail(txAvail), .txFull(txFull),
    .txHalfEmpty(txHalfEmpty), .rxEmpty(rxEmpty), .rxFull(rxFull), .rts(rts),
    .overrun(overrun), .frameErr(frameErr), .irq(irq));
endmodule

// File: rtl/irUartChk.sv
module irUartChk #(
  parameter int PRESC_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [PRESC_W-1:0] presc,
  input logic              irMode,
  input logic              txd,
  input logic              rxFull,
  input logic              overrun,
  input logic              rtsAuto,
  input logic              rts,
  input logic              txFull,
  input logic              txHalfEmpty
);
  logic [15:0] hiRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hiRun <= '0;
    else       hiRun <= (irMode && txd) ? hiRun + 1'b1 : '0;
  end

  assert_ir_pulse_width_R3: assert property (@(posedge clk) disable iff (!rstN)
    (irMode && txd) |-> (32'(hiRun) < (3 << presc)));

  assert_half_vs_full_R8: assert property (@(posedge clk) disable iff (!rstN)
    txFull |-> !txHalfEmpty);

  assert_overrun_needs_full_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(rxFull));

  assert_rts_throttle_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rtsAuto && rxFull) |-> !rts);
endmodule

bind irUart irUartChk #(.PRESC_W(PRESC_W)) chk (
  .clk(clk), .rstN(rstN), .presc(presc), .irMode(irMode), .txd(txd),
  .rxFull(rxFull), .overrun(overrun), .rtsAuto(rtsAuto), .rts(rts),
  .txFull(txFull), .txHalfEmpty(txHalfEmpty));

// File: tb/irUart_test.sv
`timescale 1ns/1ps
module irUart_test;
  logic clk = 0, rstN = 0;
  logic [2:0] presc = 0;
  logic irMode = 0, rx1x = 0, irLoop = 0, rtsAuto = 1, rtsSoft = 0;
  logic wrEn = 0, rdEn = 0, cts = 1, rxdDrv = 1, loopNrz = 0;
  logic [7:0] wrData = 0, rdData;
  logic txFull, txHalfEmpty, rxEmpty, rxFull, overrun, frameErr, irq, txd, rts, rxd;
  int checks = 0, errors = 0, cyc = 0;

  assign rxd = loopNrz ? txd : rxdDrv;

  irUart uut (.clk(clk), .rstN(rstN), .presc(presc), .irMode(irMode), .rx1x(rx1x),
    .irLoop(irLoop), .rtsAuto(rtsAuto), .rtsSoft(rtsSoft), .wrEn(wrEn), .wrData(wrData),
    .txFull(txFull), .txHalfEmpty(txHalfEmpty), .rdEn(rdEn), .rdData(rdData),
    .rxEmpty(rxEmpty), .rxFull(rxFull), .overrun(overrun), .frameErr(frameErr),
    .irq(irq), .rxd(rxd), .txd(txd), .cts(cts), .rts(rts));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick1();
    @(posedge clk); #1;
  endtask

  task automatic wrByte(input logic [7:0] b);
    wrData = b; wrEn = 1; tick1(); wrEn = 0;
  endtask

  task automatic readByte(input string tag, input logic [7:0] exp);
    check({tag, " not empty"}, rxEmpty, 0);
    check({tag, " data"}, rdData, exp);
    rdEn = 1; tick1(); rdEn = 0;
  endtask

  task automatic drive(input logic v, input int n);
    rxdDrv = v; repeat (n) tick1();
  endtask

  task automatic sendNrz(input logic [7:0] b, input logic stopV, input int bt);
    drive(0, bt);
    for (int i = 0; i < 8; i++) drive(b[i], bt);
    drive(stopV, bt);
    drive(1, bt);
  endtask

  task automatic irBit(input logic v, input int tk);
    if (!v) begin drive(1, 3 * tk); drive(0, 13 * tk); end
    else drive(0, 16 * tk);
  endtask

  task automatic sendIr(input logic [7:0] b, input int tk);
    irBit(0, tk);
    for (int i = 0; i < 8; i++) irBit(b[i], tk);
    irBit(1, tk);
    drive(0, 16 * tk);
  endtask

  task automatic captureTx(input int bt, output logic [7:0] b, output logic good);
    logic s0, s1;
    while (txd !== 1'b0) tick1();
    repeat (bt / 2) tick1();
    s0 = txd;
    for (int i = 0; i < 8; i++) begin repeat (bt) tick1(); b[i] = txd; end
    repeat (bt) tick1();
    s1 = txd;
    good = !s0 && s1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic good;
    int n, pulses, badW, d, s;
    logic prev, sawLow;

    repeat (3) tick1();
    // R1 reset state
    check("R1 txd", txd, 1); check("R1 rxEmpty", rxEmpty, 1);
    check("R1 txHalfEmpty", txHalfEmpty, 1); check("R1 overrun", overrun, 0);
    check("R1 frameErr", frameErr, 0); check("R1 irq", irq, 0);
    rstN = 1; tick1();

    // R2 level-mode frame
    wrByte(8'hA5);
    captureTx(16, b, good);
    check("R2 tx byte", b, 8'hA5); check("R2 start/stop", good, 1);
    repeat (40) tick1();

    // R2 prescaler: code 2 gives 64-cycle bits
    presc = 2; wrByte(8'h81);
    while (txd !== 1'b0) tick1();
    n = 0;
    while (txd == 1'b0) begin n++; tick1(); end
    check("R2 bit length presc=2", n, 64);
    repeat (11 * 64) tick1();
    presc = 0; repeat (20) tick1();

    // R4 16x receive, R13 irq
    sendNrz(8'h3C, 1, 16);
    check("R13 irq on data", irq, 1);
    readByte("R4 rx 16x", 8'h3C);
    check("R13 irq clear", irq, 0);
    rdEn = 1; tick1(); rdEn = 0;
    check("R4 rdEn on empty", rxEmpty, 1);

    // R10 framing error
    sendNrz(8'h77, 0, 16);
    check("R10 frameErr set", frameErr, 1);
    readByte("R10 bad-stop byte kept", 8'h77);
    check("R13 irq from frameErr", irq, 1);
    sendNrz(8'h12, 1, 16);
    check("R10 frameErr clear", frameErr, 0);
    readByte("R10 good byte", 8'h12);

    // R3 infrared transmit, presc=1 -> 6-cycle pulses
    rxdDrv = 0; repeat (4) tick1();
    irMode = 1; presc = 1; repeat (40) tick1();
    check("R3 ir idle low", txd, 0);
    wrByte(8'h0F);
    pulses = 0; badW = 0; n = 0; prev = 0;
    repeat (13 * 32) begin
      if (txd && !prev) pulses++;
      if (txd) n++;
      if (!txd && prev) begin if (n != 6) badW++; n = 0; end
      prev = txd; tick1();
    end
    check("R3 pulse count", pulses, 5);
    check("R3 pulse widths wrong", badW, 0);
    check("R4 ir tx not looped", rxEmpty, 1);

    // R5 infrared loopback
    presc = 0; irLoop = 1; repeat (20) tick1();
    wrByte(8'hA5);
    repeat (13 * 16 + 20) tick1();
    readByte("R5 ir loop", 8'hA5);
    irLoop = 0; repeat (20) tick1();

    // R5 infrared receive from the line
    sendIr(8'h3C, 1);
    readByte("R5 ir rx", 8'h3C);
    irMode = 0; rxdDrv = 1; repeat (40) tick1();
    check("R5 no spurious byte", rxEmpty, 1);

    // R6 1x receive through an external wire loop
    rx1x = 1; loopNrz = 1; repeat (20) tick1();
    wrByte(8'h96);
    repeat (13 * 16 + 20) tick1();
    readByte("R6 rx 1x", 8'h96);
    loopNrz = 0; rx1x = 0; repeat (20) tick1();

    // R12 cts hold, R8 half empty, R7 tx depth
    cts = 0;
    for (int i = 0; i < 3; i++) wrByte(8'h40 + 8'(i));
    check("R8 three queued", txHalfEmpty, 1);
    wrByte(8'h43);
    check("R8 four queued", txHalfEmpty, 0);
    for (int i = 4; i < 8; i++) wrByte(8'h40 + 8'(i));
    check("R7 txFull", txFull, 1);
    wrByte(8'hEE);
    sawLow = 0;
    repeat (100) begin if (!txd) sawLow = 1; tick1(); end
    check("R12 held by cts", sawLow, 0);
    cts = 1;
    for (int i = 0; i < 8; i++) begin
      captureTx(16, b, good);
      check("R12 queued byte", b, 8'h40 + 8'(i));
      check("R2 queued frame", good, 1);
    end
    sawLow = 0;
    repeat (400) begin if (!txd) sawLow = 1; tick1(); end
    check("R7 write while full dropped", sawLow, 0);
    check("R8 empty queue", txHalfEmpty, 1);

    // R11 rts, R7 rx depth, R9 overrun and same-cycle read
    check("R11 rts empty", rts, 1);
    s = cyc;
    fork
      sendNrz(8'h10, 1, 16);
      begin while (rxEmpty) tick1(); d = cyc - s; end
    join
    for (int i = 1; i < 8; i++) begin
      sendNrz(8'h10 + 8'(i), 1, 16);
      if (i == 5) check("R11 rts six held", rts, 1);
      if (i == 6) check("R11 rts seven held", rts, 0);
    end
    check("R7 rxFull", rxFull, 1);
    rtsAuto = 0; rtsSoft = 1; #1 check("R11 soft rts 1", rts, 1);
    rtsSoft = 0; #1 check("R11 soft rts 0", rts, 0);
    rtsAuto = 1;
    sendNrz(8'h55, 1, 16);
    check("R9 overrun set", overrun, 1);
    check("R13 irq", irq, 1);
    check("R9 head before overlap", rdData, 8'h10);
    s = cyc;
    fork
      sendNrz(8'h66, 1, 16);
      begin while (cyc != s + d - 1) tick1(); rdEn = 1; tick1(); rdEn = 0; end
    join
    check("R9 overlap clears overrun", overrun, 0);
    check("R9 overlap keeps full", rxFull, 1);
    for (int i = 1; i < 8; i++) readByte("R9 drain", 8'h10 + 8'(i));
    readByte("R9 overlapped byte", 8'h66);
    check("R9 drained", rxEmpty, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule